// File: doc/BRIEF.md
# Adaptive TDMA Slot Timer

This block keeps the slot schedule of a node in a time-slotted network when the node's only time base is a cheap, fast-drifting local oscillator. It counts enabled local ticks to find where each slot begins, where the frame of slots begins, and the instant inside each slot at which a packet is to leave the radio. All durations are held as tick counts. The transmit offset is always one fifth of the slot length, so a 100-tick slot transmits at tick 20.

When a packet from the time parent starts arriving, the block stamps it with the in-slot tick count and subtracts the transmit offset. The result, clamped to half a slot, is the sync error. The slot that begins at the next boundary is stretched or shortened by that amount, which pulls the local phase onto the parent's. Each nonzero error also moves a signed tally up (late arrival) or down (early arrival), and every error goes into a short history. When the tally's magnitude reaches a threshold, the slot length itself is retuned by the history's mean divided by the slots per frame. This lets the node follow the parent's clock rate and not only its phase.

Top module: `adaptive_slot_timer`

## Requirements
- R1: While reset is high, `slot_dur` loads `cfg_slot_init`, the transmit offset becomes floor(`cfg_slot_init`/5), and `slot_tgl`, `frame_tgl`, `tx_fire` and `sync_err` are 0.
- R2: With no correction pending, `slot_tgl` flips once every `slot_dur` cycles in which `tick_en` is high. Cycles with `tick_en` low do not advance the in-slot count, which starts at 0 on each slot start.
- R3: `frame_tgl` flips together with the `slot_tgl` flip that begins slot index 0. Indices run 0 to 2^SLOTS_LOG2-1, so a frame holds 2^SLOTS_LOG2 slots.
- R4: `tx_fire` is high for exactly the one cycle after the enabled tick that moves the in-slot count from offset-1 to the offset, where the offset is floor(`slot_dur`/5).
- R5: A sync event is a cycle with both `rx_start` and `sync_valid` high. Its error is the in-slot count in that cycle minus the offset, clamped to the range -floor(`slot_dur`/2) to +floor(`slot_dur`/2). It appears on `sync_err` (two's complement) one cycle later. `rx_start` with `sync_valid` low changes neither `sync_err` nor the slot timing.
- R6: The slot that starts at the first boundary after a sync event lasts `slot_dur` plus that event's clamped error. A positive error delays the schedule and a negative one advances it. Later slots return to `slot_dur`.
- R7: Each sync event with a positive error adds 1 to a signed tally, a negative one subtracts 1, and a zero error leaves it. When the tally's magnitude reaches THRESH, a retune happens in that event's cycle and the tally is cleared.
- R8: On a retune, `slot_dur` (visible one cycle later) becomes `slot_dur` plus the sum of the last 2^BUF_LOG2 errors, the current one included, arithmetically shifted right by BUF_LOG2+SLOTS_LOG2 (rounding toward minus infinity). The offset becomes floor of the new length over 5, and the history is emptied. `slot_dur` changes at no other time after reset.
- R9: When a sync event falls on the last tick of a slot, the slot starting at that boundary uses the correction pending from earlier (or none). The new error applies at the boundary after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One local oscillator tick in this cycle |
| rx_start | input | 1 | Pulse at the start of packet reception |
| sync_valid | input | 1 | The receiving packet comes from the time parent |
| cfg_slot_init | input | TW | Slot length in ticks loaded during reset |
| slot_tgl | output | 1 | Flips at every slot start |
| frame_tgl | output | 1 | Flips at every slotframe start |
| tx_fire | output | 1 | One-cycle transmit strobe |
| slot_dur | output | TW | Current learned slot length in ticks |
| sync_err | output | TW+1 | Last clamped sync error, signed |

## Verification
The bench builds the block with a four-entry history, four slots per frame and a threshold of 6 instead of 20, with a 100-tick starting slot. This puts several retunes, including ones driven by runs of early arrivals, inside a short run. With one-fifth and one-half of 100 landing on whole numbers, an event at tick 95 hits the upper clamp and one at tick 0 gives an exact -20. A four-entry mean of -15 divided by four slots lands between integers, which exercises the rounding direction of the retune shift.

// File: rtl/ast_pkg.sv
package ast_pkg;
  // transmit offset is one fifth of the slot length, floored
  function automatic logic [31:0] div5(input logic [31:0] v);
    return v / 32'd5;
  endfunction
endpackage

// File: rtl/ast_slot_ctr.sv
module ast_slot_ctr #(
  parameter int TW         = 16,
  parameter int SLOTS_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic [TW-1:0]        init_len,
  input  logic [TW-1:0]        base_len,
  input  logic signed [TW:0]   pend,
  input  logic [TW-1:0]        tx_off,
  output logic [TW-1:0]        cnt,
  output logic                 bnd,
  output logic                 slot_tgl,
  output logic                 frame_tgl,
  output logic                 tx_fire
);
  logic [TW-1:0]         len_q;
  logic [SLOTS_LOG2-1:0] idx_q;
  logic signed [TW:0]    next_len;

  assign bnd      = tick_en && (cnt == len_q - 1'b1);
  assign next_len = $signed({1'b0, base_len}) + pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      len_q     <= init_len;
      idx_q     <= '0;
      slot_tgl  <= 1'b0;
      frame_tgl <= 1'b0;
      tx_fire   <= 1'b0;
    end else begin
      tx_fire <= tick_en && !bnd && ((cnt + 1'b1) == tx_off);
      if (bnd) begin
        cnt      <= '0;
        len_q    <= next_len[TW-1:0];
        slot_tgl <= ~slot_tgl;
        idx_q    <= idx_q + 1'b1;
        if (&idx_q) frame_tgl <= ~frame_tgl;
      end else if (tick_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ast_err_hist.sv
module ast_err_hist #(
  parameter int EW         = 17,
  parameter int DEPTH_LOG2 = 4,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int SW        = EW + DEPTH_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 clr,
  input  logic signed [EW-1:0] din,
  output logic signed [SW-1:0] sum,
  output logic signed [EW-1:0] oldest,
  output logic                 full
);
  logic signed [EW-1:0]  mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wp;
  logic [DEPTH_LOG2:0]   n;
  logic signed [EW-1:0]  drop;

  assign oldest = mem[wp];
  assign full   = (n == (DEPTH_LOG2+1)'(DEPTH));
  assign drop   = full ? oldest : '0;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      n   <= '0;
      sum <= '0;
    end else if (wr) begin
      wp  <= wp + 1'b1;
      if (!full) n <= n + 1'b1;
      sum <= sum + SW'(din) - SW'(drop);
    end
  end
endmodule

// File: rtl/adaptive_slot_timer.sv
module adaptive_slot_timer #(
  parameter int TW         = 16,
  parameter int SLOTS_LOG2 = 2,
  parameter int BUF_LOG2   = 4,
  parameter int THRESH     = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                rx_start,
  input  logic                sync_valid,
  input  logic [TW-1:0]       cfg_slot_init,
  output logic                slot_tgl,
  output logic                frame_tgl,
  output logic                tx_fire,
  output logic [TW-1:0]       slot_dur,
  output logic signed [TW:0]  sync_err
);
  localparam int EW    = TW + 1;
  localparam int SW    = EW + BUF_LOG2;
  localparam int CW    = $clog2(THRESH + 1) + 1;
  localparam int SHIFT = BUF_LOG2 + SLOTS_LOG2;
  localparam logic signed [CW-1:0] ONE   = CW'(1);
  localparam logic signed [CW-1:0] THR_S = CW'(THRESH);

  logic [TW-1:0]         cnt, tx_off;
  logic                  bnd, evt, hit, full;
  logic signed [EW-1:0]  raw_err, half, sat, pend, oldest, old_term;
  logic signed [CW-1:0]  sc_q, sc_nx, sc_abs;
  logic signed [SW-1:0]  hsum, total, corr, new_w;
  logic [TW-1:0]         new_dur;

  assign evt     = rx_start && sync_valid;
  assign raw_err = $signed({1'b0, cnt}) - $signed({1'b0, tx_off});
  assign half    = $signed({2'b00, slot_dur[TW-1:1]});

  always_comb begin
    if (raw_err > half)       sat = half;
    else if (raw_err < -half) sat = -half;
    else                      sat = raw_err;
    if (sat > 0)      sc_nx = sc_q + ONE;
    else if (sat < 0) sc_nx = sc_q - ONE;
    else              sc_nx = sc_q;
    sc_abs = sc_nx[CW-1] ? -sc_nx : sc_nx;
  end

  assign hit      = evt && (sc_abs == THR_S);
  assign old_term = full ? oldest : '0;
  assign total    = hsum + SW'(sat) - SW'(old_term);
  assign corr     = total >>> SHIFT;
  assign new_w    = SW'($signed({1'b0, slot_dur})) + corr;
  assign new_dur  = new_w[TW-1:0];

  ast_slot_ctr #(.TW(TW), .SLOTS_LOG2(SLOTS_LOG2)) u_ctr (
    .clk(clk), .rst(rst), .tick_en(tick_en), .init_len(cfg_slot_init),
    .base_len(slot_dur), .pend(pend), .tx_off(tx_off), .cnt(cnt), .bnd(bnd),
    .slot_tgl(slot_tgl), .frame_tgl(frame_tgl), .tx_fire(tx_fire)
  );

  ast_err_hist #(.EW(EW), .DEPTH_LOG2(BUF_LOG2)) u_hist (
    .clk(clk), .rst(rst), .wr(evt), .clr(hit), .din(sat),
    .sum(hsum), .oldest(oldest), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_dur <= cfg_slot_init;
      tx_off   <= TW'(ast_pkg::div5(32'(cfg_slot_init)));
      sc_q     <= '0;
      pend     <= '0;
      sync_err <= '0;
    end else begin
      if (bnd) pend <= '0;
      if (evt) begin
        pend     <= sat;
        sync_err <= sat;
        if (hit) begin
          sc_q     <= '0;
          slot_dur <= new_dur;
          tx_off   <= TW'(ast_pkg::div5(32'(new_dur)));
        end else begin
          sc_q <= sc_nx;
        end
      end
    end
  end
endmodule

// File: rtl/ast_checker.sv
module ast_checker #(
  parameter int TW     = 16,
  parameter int THRESH = 20,
  parameter int CW     = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                rx_start,
  input logic                sync_valid,
  input logic                slot_tgl,
  input logic                frame_tgl,
  input logic                tx_fire,
  input logic [TW-1:0]       slot_dur,
  input logic signed [TW:0]  sync_err,
  input logic signed [CW-1:0] sc_q
);
  localparam logic signed [CW-1:0] THR = CW'(THRESH);
  logic [TW+1:0] err_mag;
  assign err_mag = sync_err[TW] ? $unsigned(-{sync_err[TW], sync_err})
                                : $unsigned({sync_err[TW], sync_err});

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!slot_tgl && !frame_tgl && !tx_fire && sync_err == '0));

  a_r2_slot_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(slot_tgl));

  a_r3_frame_with_slot: assert property (@(posedge clk) disable iff (rst)
    (frame_tgl != $past(frame_tgl)) |-> (slot_tgl != $past(slot_tgl)));

  a_r5_ignored_rx: assert property (@(posedge clk) disable iff (rst)
    !(rx_start && sync_valid) |=> $stable(sync_err));

  a_r5_err_clamped: assert property (@(posedge clk) disable iff (rst)
    (rx_start && sync_valid) |=> (err_mag <= {2'b00, $past(slot_dur) >> 1}));

  a_r7_tally_bound: assert property (@(posedge clk) disable iff (rst)
    (sc_q < THR) && (sc_q > -THR));

  a_r8_dur_only_on_sync: assert property (@(posedge clk) disable iff (rst)
    !(rx_start && sync_valid) |=> $stable(slot_dur));
endmodule

bind adaptive_slot_timer ast_checker #(.TW(TW), .THRESH(THRESH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .rx_start(rx_start),
  .sync_valid(sync_valid), .slot_tgl(slot_tgl), .frame_tgl(frame_tgl),
  .tx_fire(tx_fire), .slot_dur(slot_dur), .sync_err(sync_err), .sc_q(sc_q)
);

// File: tb/tb_adaptive_slot_timer.sv
module tb_adaptive_slot_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16, SL = 2, BL = 2, TH = 6;
  localparam int SPF = 1 << SL, DEP = 1 << BL;
  localparam int INIT = 100;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, rx_start = 1'b0, sync_valid = 1'b0;
  logic [TW-1:0] cfg_slot_init = TW'(INIT);
  logic slot_tgl, frame_tgl, tx_fire;
  logic [TW-1:0] slot_dur;
  logic signed [TW:0] sync_err;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string g_tag = "R1";

  // reference state
  int m_cnt, m_len, m_idx, m_dur, m_off, m_pend, m_sc, m_err, m_n, m_wp;
  bit m_st, m_ft, m_fire;
  int hq[DEP];

  adaptive_slot_timer #(.TW(TW), .SLOTS_LOG2(SL), .BUF_LOG2(BL), .THRESH(TH)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rx_start(rx_start),
    .sync_valid(sync_valid), .cfg_slot_init(cfg_slot_init), .slot_tgl(slot_tgl),
    .frame_tgl(frame_tgl), .tx_fire(tx_fire), .slot_dur(slot_dur), .sync_err(sync_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", g_tag, what, act, exp, cyc);
    end
  endtask

  function automatic int clampv(int v, int h);
    if (v > h) return h;
    if (v < -h) return -h;
    return v;
  endfunction

  function automatic int floor_shift(int v, int s);
    return v >>> s;
  endfunction

  task automatic m_init();
    m_cnt = 0; m_len = INIT; m_idx = 0; m_dur = INIT; m_off = INIT / 5;
    m_pend = 0; m_sc = 0; m_err = 0; m_n = 0; m_wp = 0;
    m_st = 0; m_ft = 0; m_fire = 0;
  endtask

  task automatic compare_all();
    chk("slot_tgl", int'(slot_tgl), int'(m_st));
    chk("frame_tgl", int'(frame_tgl), int'(m_ft));
    chk("tx_fire", int'(tx_fire), int'(m_fire));
    chk("slot_dur", int'(slot_dur), m_dur);
    chk("sync_err", int'($signed(sync_err)), m_err);
  endtask

  // one cycle: check outputs, drive inputs, advance the reference
  task automatic step(bit tk, bit rx, bit sv);
    bit bnd, evt, fire_n;
    int sat, sc_n, tot;
    compare_all();
    tick_en = tk; rx_start = rx; sync_valid = sv;
    bnd = tk && (m_cnt == m_len - 1);
    evt = rx && sv;
    sat = clampv(m_cnt - m_off, m_dur / 2);
    fire_n = tk && !bnd && (m_cnt + 1 == m_off);
    if (bnd) begin
      m_cnt = 0; m_len = m_dur + m_pend; m_st = !m_st;
      if (m_idx == SPF - 1) begin m_idx = 0; m_ft = !m_ft; end
      else m_idx++;
      m_pend = 0;
    end else if (tk) m_cnt++;
    m_fire = fire_n;
    if (evt) begin
      m_pend = sat; m_err = sat;
      sc_n = m_sc + ((sat > 0) ? 1 : ((sat < 0) ? -1 : 0));
      hq[m_wp] = sat; m_wp = (m_wp + 1) % DEP; if (m_n < DEP) m_n++;
      if (sc_n == TH || sc_n == -TH) begin
        tot = 0;
        for (int i = 0; i < m_n; i++) tot += hq[i];
        m_dur = m_dur + floor_shift(tot, BL + SL);
        m_off = m_dur / 5; m_sc = 0; m_n = 0; m_wp = 0;
      end else m_sc = sc_n;
    end
    @(negedge clk);
  endtask

  task automatic evt_at(int c);
    for (int k = 0; k < 1000 && m_cnt != c; k++) step(1, 0, 0);
    step(1, 1, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_init();
    repeat (3) @(negedge clk);
    g_tag = "R1";
    chk("slot_tgl", int'(slot_tgl), 0);
    chk("frame_tgl", int'(frame_tgl), 0);
    chk("tx_fire", int'(tx_fire), 0);
    chk("sync_err", int'($signed(sync_err)), 0);
    chk("slot_dur", int'(slot_dur), INIT);
    rst = 1'b0;

    g_tag = "R2_R3_R4";
    for (int i = 0; i < 450; i++) step(1, 0, 0);
    for (int i = 0; i < 900; i++) step(($urandom % 10) < 7, 0, 0);

    g_tag = "R5";
    for (int i = 0; i < 300; i++) step(1, ($urandom % 6) == 0, 0);
    evt_at(95);                       // +75 clamps to +50
    step(1, 0, 0);
    chk("clamp high", int'($signed(sync_err)), 50);
    evt_at(0);                        // exact -20
    step(1, 0, 0);
    chk("early error", int'($signed(sync_err)), -20);

    g_tag = "R6";
    evt_at(30);                       // +10 stretches the next slot
    for (int i = 0; i < 350; i++) step(1, 0, 0);
    evt_at(50);
    for (int i = 0; i < 350; i++) step(($urandom % 4) != 0, 0, 0);

    g_tag = "R7_R8";
    for (int j = 0; j < 2 * TH; j++) begin
      evt_at(5);
      for (int i = 0; i < 20; i++) step(1, 0, 0);
    end
    evt_at(m_off);                    // zero error leaves tally
    for (int j = 0; j < 2 * TH; j++) evt_at(m_off + 7);

    g_tag = "R9";
    for (int j = 0; j < 4; j++) begin
      evt_at(m_len - 1);
      for (int i = 0; i < 250; i++) step(1, 0, 0);
    end

    g_tag = "R5_R6_R7_R8";
    for (int i = 0; i < 30000; i++) begin
      bit tk, rx, sv;
      int d;
      tk = ($urandom % 8) != 0;
      d = m_cnt - m_off;
      rx = ((d > -12 && d < 12) && ($urandom % 10) == 0) || (($urandom % 400) == 0);
      sv = ($urandom % 8) != 0;
      step(tk, rx, sv);
    end
    compare_all();
    finish_run();
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end
endmodule